// File: doc/BRIEF.md
# Hyperbolic Cosine and Sine Pipeline (Mixed Radix)

This block evaluates cosh and sinh of a small signed angle. It uses only shifts, adders and multiplexers. The angle arrives as a 16-bit two's-complement word with 14 fractional bits. The angle is expected to lie within plus or minus one half. A valid flag travels with each sample through a chain of registered rotation stages, and the two results leave on matching 16-bit words that also carry 14 fractional bits.

The first eight stages rotate by binary steps, with step indices 2 through 9. Each of these stages picks its direction from the sign of the remaining angle. Four more stages follow, with step indices 4 through 7. Each of these picks a digit from {-2, -1, 0, +1, +2} by comparing the remaining angle against two thresholds. The starting x coordinate is loaded with the inverse of the gain of the binary stages, so the results need no correction afterwards. The gain of the digit stages is so close to one that it is ignored.

A new angle may enter on every clock. Idle cycles pass through as idle outputs, and results leave in the order the angles arrived.

Top module: `hyp_cordic_mr`

## Requirements
- R1: out_valid is high in exactly the 12th cycle after a cycle with in_valid high (8 binary stages plus 4 digit stages, one register each).
- R2: In the cycle after rst_n is sampled low, out_valid is 0 and out_cosh and out_sinh are both 0, whatever was in flight.
- R3: For in_angle in [-8192, 8192] (14 fractional bits, so [-0.5, 0.5]), out_cosh and out_sinh differ from 16384·cosh and 16384·sinh of that angle by at most 6 LSB.
- R4: A zero angle gives out_cosh within 6 LSB of 16384 and out_sinh within 6 LSB of 0.
- R5: Angles presented on consecutive cycles each produce one result, in arrival order, with no cycle lost.
- R6: A cycle with in_valid low produces a cycle with out_valid low 12 cycles later, and it does not disturb the results of its valid neighbours.
- R7: After the last binary stage, the remaining angle of a valid sample lies within ±2.5·4^-4.
- R8: After each digit stage of index j, the remaining angle of a valid sample lies within ±0.5·4^-j, plus a few internal LSB for constant rounding.
- R9: Whenever out_valid is high, out_cosh is at least 16384 − 6 and at least |out_sinh|.
- R10: The end points in_angle = 8192 and in_angle = −8192 meet the R3 bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_angle as a sample to evaluate |
| in_angle | input | 16 | Signed angle, 14 fractional bits, within ±0.5 |
| out_valid | output | 1 | Marks the result words as a finished sample |
| out_cosh | output | 16 | Signed hyperbolic cosine, 14 fractional bits |
| out_sinh | output | 16 | Signed hyperbolic sine, 14 fractional bits |

## Verification
A corrupted rotation constant, a wrong shift or a wrong digit choice in any stage reaches the ports exactly 12 cycles after the affected angle entered. It shows there as a cosh or sinh error larger than a few LSB, and it affects only the angles whose path used that stage's bad case. A lost or duplicated valid bit shows as a misplaced out_valid at that same cycle. A remaining angle that goes out of bounds is flagged one cycle after the stage that produced it, before any output error appears. The bench covers zero, both end points, a dense sweep and a gapped stream, so that the selection of each digit is exercised with both signs.

// File: rtl/hcordic_pkg.sv
// Shared definitions for the mixed-radix hyperbolic rotation pipeline.
// Assumes real arithmetic is available for elaboration-time constants only.
package hcordic_pkg;

    // Digit chosen by a higher-radix stage.
    typedef enum logic [2:0] {
        DIG_NEG2,
        DIG_NEG1,
        DIG_ZERO,
        DIG_POS1,
        DIG_POS2
    } digit_e;

    // Inverse hyperbolic tangent in real arithmetic.
    function automatic real atanh_real(input real t);
        return 0.5 * $ln((1.0 + t) / (1.0 - t));
    endfunction

    // round(atanh(mult * 2^-shift) * 2^frac) for a positive argument.
    function automatic int atanh_fix(input int shift, input int mult, input int frac);
        real t;
        t = real'(mult) / (2.0 ** shift);
        return $rtoi(atanh_real(t) * (2.0 ** frac) + 0.5);
    endfunction

    // round(2^frac / K), where K is the gain of binary stages first..last.
    function automatic int inv_gain_fix(input int first, input int last, input int frac);
        real p;
        p = 1.0;
        for (int j = first; j <= last; j++) begin
            p = p * (1.0 - 2.0 ** (-2 * j));
        end
        return $rtoi((2.0 ** frac) / $sqrt(p) + 0.5);
    endfunction

endpackage

// File: rtl/hcordic_r2_stage.sv
// One binary hyperbolic rotation step with index SHIFT.
// The direction is +1 when the remaining angle is zero or positive, and -1 otherwise.
// Assumes the operands are wide enough that the shifted sums do not wrap.
module hcordic_r2_stage #(
    parameter int IW    = 21,
    parameter int SHIFT = 2,
    parameter int STEP  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vi,
    input  logic signed [IW-1:0] xi,
    input  logic signed [IW-1:0] yi,
    input  logic signed [IW-1:0] zi,
    output logic                 vo,
    output logic signed [IW-1:0] xo,
    output logic signed [IW-1:0] yo,
    output logic signed [IW-1:0] zo
);
    localparam logic signed [IW-1:0] ANG = IW'(STEP);

    logic                 neg;
    logic signed [IW-1:0] xsh, ysh, xn, yn, zn;

    // Rotate one step toward a zero remaining angle.
    always_comb begin
        neg = zi[IW-1];
        xsh = yi >>> SHIFT;
        ysh = xi >>> SHIFT;
        xn  = neg ? xi - xsh : xi + xsh;
        yn  = neg ? yi - ysh : yi + ysh;
        zn  = neg ? zi + ANG : zi - ANG;
    end

    // Stage register; the valid bit moves with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vo <= 1'b0;
            xo <= '0;
            yo <= '0;
            zo <= '0;
        end else begin
            vo <= vi;
            xo <= xn;
            yo <= yn;
            zo <= zn;
        end
    end

    // R1: every stage delays the valid flag by exactly one cycle.
    a_r1_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vo == $past(vi)));

endmodule

// File: rtl/hcordic_r4_stage.sv
// One higher-radix hyperbolic rotation step with index J (digit step 4^-J).
// The digit in {-2..2} comes from two threshold comparisons on the remaining angle.
// No gain correction is applied: for J >= 4 the gain differs from one by less than 4e-5.
// Assumes IFRAC >= 2*J+1 and a remaining angle at the input within 2.5*4^-J.
module hcordic_r4_stage #(
    parameter int IW    = 21,
    parameter int IFRAC = 18,
    parameter int J     = 4,
    parameter int STEP1 = 0,
    parameter int STEP2 = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vi,
    input  logic signed [IW-1:0] xi,
    input  logic signed [IW-1:0] yi,
    input  logic signed [IW-1:0] zi,
    output logic                 vo,
    output logic signed [IW-1:0] xo,
    output logic signed [IW-1:0] yo,
    output logic signed [IW-1:0] zo
);
    import hcordic_pkg::*;

    localparam int SH1 = 2 * J;
    localparam int SH2 = 2 * J - 1;
    localparam logic signed [IW-1:0] HALF  = IW'(1) <<< (IFRAC - 2 * J - 1);
    localparam logic signed [IW-1:0] THR3  = 3 * HALF;
    localparam logic signed [IW-1:0] ANG1  = IW'(STEP1);
    localparam logic signed [IW-1:0] ANG2  = IW'(STEP2);
    localparam logic signed [IW-1:0] SLACK = IW'(4);

    digit_e               dig;
    logic signed [IW-1:0] xs1, xs2, ys1, ys2, xn, yn, zn;

    // Choose the digit nearest to the remaining angle in units of 4^-J.
    always_comb begin
        if (zi >= THR3)       dig = DIG_POS2;
        else if (zi >= HALF)  dig = DIG_POS1;
        else if (zi > -HALF)  dig = DIG_ZERO;
        else if (zi > -THR3)  dig = DIG_NEG1;
        else                  dig = DIG_NEG2;
    end

    // Apply the chosen digit with shifts and adds only.
    always_comb begin
        xs1 = yi >>> SH1;
        xs2 = yi >>> SH2;
        ys1 = xi >>> SH1;
        ys2 = xi >>> SH2;
        unique case (dig)
            DIG_POS2: begin xn = xi + xs2; yn = yi + ys2; zn = zi - ANG2; end
            DIG_POS1: begin xn = xi + xs1; yn = yi + ys1; zn = zi - ANG1; end
            DIG_NEG1: begin xn = xi - xs1; yn = yi - ys1; zn = zi + ANG1; end
            DIG_NEG2: begin xn = xi - xs2; yn = yi - ys2; zn = zi + ANG2; end
            default:  begin xn = xi;       yn = yi;       zn = zi;        end
        endcase
    end

    // Stage register; the valid bit moves with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vo <= 1'b0;
            xo <= '0;
            yo <= '0;
            zo <= '0;
        end else begin
            vo <= vi;
            xo <= xn;
            yo <= yn;
            zo <= zn;
        end
    end

    // R1: every stage delays the valid flag by exactly one cycle.
    a_r1_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vo == $past(vi)));

    // R8: the remaining angle after this stage is within half a digit step.
    a_r8_stage_residual: assert property (@(posedge clk) disable iff (!rst_n)
        vo |-> ((zo <= HALF + SLACK) && (zo >= -HALF - SLACK)));

endmodule

// File: rtl/hyp_cordic_mr.sv
// Fully pipelined cosh/sinh evaluator: binary hyperbolic rotation stages
// (indices R2_FIRST..R2_LAST), then R4_STAGES digit stages from index R4_FIRST.
// Assumes the input angle lies within +-0.5; results are unscaled because x starts
// at the inverse binary gain. Latency is one cycle per stage.
module hyp_cordic_mr #(
    parameter int DW        = 16,
    parameter int FRAC      = 14,
    parameter int GUARD     = 4,
    parameter int R2_FIRST  = 2,
    parameter int R2_LAST   = 9,
    parameter int R4_FIRST  = 4,
    parameter int R4_STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_angle,
    output logic          out_valid,
    output logic [DW-1:0] out_cosh,
    output logic [DW-1:0] out_sinh
);
    import hcordic_pkg::*;

    localparam int IW       = DW + GUARD + 1;
    localparam int IFRAC    = FRAC + GUARD;
    localparam int N2       = R2_LAST - R2_FIRST + 1;
    localparam int LAT      = N2 + R4_STAGES;
    localparam int INV_GAIN = inv_gain_fix(R2_FIRST, R2_LAST, IFRAC);
    localparam logic signed [IW-1:0] COARSE_LIM = IW'(5) <<< (IFRAC - 2 * R4_FIRST - 1);
    localparam logic signed [IW-1:0] ROUND_ADD  = IW'(1) <<< (GUARD - 1);
    localparam logic signed [DW-1:0] ONE_TOL    = DW'((1 << FRAC) - 6);

    logic                 vs [0:LAT];
    logic signed [IW-1:0] xs [0:LAT];
    logic signed [IW-1:0] ys [0:LAT];
    logic signed [IW-1:0] zs [0:LAT];
    logic signed [IW-1:0] rc, rs;

    // Stage 0: preload x with the inverse gain, y with zero, z with the angle.
    assign vs[0] = in_valid;
    assign xs[0] = IW'(INV_GAIN);
    assign ys[0] = '0;
    assign zs[0] = {{(IW - DW - GUARD){in_angle[DW-1]}}, in_angle, {GUARD{1'b0}}};

    // Binary rotation stages, one per index.
    for (genvar g = 0; g < N2; g++) begin : g_r2
        localparam int STP = atanh_fix(R2_FIRST + g, 1, IFRAC);
        hcordic_r2_stage #(.IW(IW), .SHIFT(R2_FIRST + g), .STEP(STP)) i_stage (
            .clk(clk), .rst_n(rst_n),
            .vi(vs[g]), .xi(xs[g]), .yi(ys[g]), .zi(zs[g]),
            .vo(vs[g+1]), .xo(xs[g+1]), .yo(ys[g+1]), .zo(zs[g+1])
        );
    end

    // Digit rotation stages refining the remaining angle.
    for (genvar g = 0; g < R4_STAGES; g++) begin : g_r4
        localparam int JJ = R4_FIRST + g;
        localparam int S1 = atanh_fix(2 * JJ, 1, IFRAC);
        localparam int S2 = atanh_fix(2 * JJ, 2, IFRAC);
        hcordic_r4_stage #(.IW(IW), .IFRAC(IFRAC), .J(JJ), .STEP1(S1), .STEP2(S2)) i_stage (
            .clk(clk), .rst_n(rst_n),
            .vi(vs[N2+g]), .xi(xs[N2+g]), .yi(ys[N2+g]), .zi(zs[N2+g]),
            .vo(vs[N2+g+1]), .xo(xs[N2+g+1]), .yo(ys[N2+g+1]), .zo(zs[N2+g+1])
        );
    end

    // Round the guard bits away to form the output words.
    always_comb begin
        rc = xs[LAT] + ROUND_ADD;
        rs = ys[LAT] + ROUND_ADD;
        out_cosh  = rc[DW+GUARD-1:GUARD];
        out_sinh  = rs[DW+GUARD-1:GUARD];
        out_valid = vs[LAT];
    end

    // R7: the binary block leaves an angle the digit block can absorb.
    a_r7_coarse_residual: assert property (@(posedge clk) disable iff (!rst_n)
        vs[N2] |-> ((zs[N2] <= COARSE_LIM) && (zs[N2] >= -COARSE_LIM)));

    // R3: the rounded results fit the output format without wrapping.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((rc >>> (DW + GUARD - 1)) == 0 || (rc >>> (DW + GUARD - 1)) == -1)
                    && ((rs >>> (DW + GUARD - 1)) == 0 || (rs >>> (DW + GUARD - 1)) == -1)
                    && (zs[LAT] <= COARSE_LIM) && (zs[LAT] >= -COARSE_LIM)));

    // R9: cosh stays near or above one and dominates |sinh|.
    a_r9_cosh_dominates: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($signed(out_cosh) >= ONE_TOL)
                    && ($signed(out_cosh) >= $signed(out_sinh))
                    && ($signed(out_cosh) >= -$signed(out_sinh))));

    // R2: a sampled reset clears the output side by the next cycle.
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= !rst_n;
    a_r2_reset_clear: assert property (@(posedge clk)
        rst_seen |-> (!out_valid && out_cosh == '0 && out_sinh == '0));

endmodule

// File: tb/test_hyp_cordic_mr.sv
`timescale 1ns/1ps
module test_hyp_cordic_mr;
    localparam int  LAT = 12;
    localparam real TOL = 6.0;
    localparam real SCL = 16384.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_angle = '0;
    logic        out_valid;
    logic [15:0] out_cosh, out_sinh;

    int tests = 0;
    int fails = 0;

    int    qv[$];
    int    qa[$];
    string qt[$];

    always #4 clk = ~clk;

    hyp_cordic_mr i_hyp_cordic_mr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
        .out_valid(out_valid), .out_cosh(out_cosh), .out_sinh(out_sinh)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input real act, input real exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
        end
    endtask

    function automatic real rabs(input real v);
        return (v < 0.0) ? -v : v;
    endfunction

    // Pop the oldest model entry and compare it with the outputs now visible.
    task automatic compare_front();
        int    v = qv.pop_front();
        int    a = qa.pop_front();
        string t = qt.pop_front();
        real   ar, ec, es, ac, as;
        chk(out_valid == v[0], (v != 0) ? "R1" : "R6", "out_valid", real'(out_valid), real'(v));
        if (v != 0 && out_valid) begin
            ar = real'(a) / SCL;
            ec = ($exp(ar) + $exp(-ar)) / 2.0 * SCL;
            es = ($exp(ar) - $exp(-ar)) / 2.0 * SCL;
            ac = real'($signed(out_cosh));
            as = real'($signed(out_sinh));
            // Accuracy also exposes any R7 or R8 residual escape.
            chk(rabs(ac - ec) <= TOL, t, "cosh", ac, ec);
            chk(rabs(as - es) <= TOL, t, "sinh", as, es);
            chk(ac >= rabs(as) && ac >= SCL - TOL, "R9", "cosh>=|sinh|", ac, rabs(as));
        end
    endtask

    // Present one input for one edge, then advance the reference model.
    task automatic tick(input bit v, input int ang, input string tag);
        in_valid = v;
        in_angle = v ? ang[15:0] : 16'h0000;
        @(posedge clk);
        #2;
        qv.push_back(int'(v));
        qa.push_back(ang);
        qt.push_back(tag);
        if (qv.size() >= LAT) compare_front();
    endtask

    // Hold reset for n edges, check the cleared outputs, then restart the model.
    task automatic do_reset(input int n);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (n) @(posedge clk);
        #2;
        chk(!out_valid, "R2", "out_valid in reset", real'(out_valid), 0.0);
        chk(out_cosh == 16'h0, "R2", "cosh in reset", real'(out_cosh), 0.0);
        chk(out_sinh == 16'h0, "R2", "sinh in reset", real'(out_sinh), 0.0);
        rst_n = 1'b1;
        qv.delete(); qa.delete(); qt.delete();
        for (int i = 0; i < LAT - 1; i++) begin
            qv.push_back(0); qa.push_back(0); qt.push_back("R2");
        end
    endtask

    initial begin
        #2;
        do_reset(3);
        // R4: zero angle.
        tick(1'b1, 0, "R4");
        // R10: both end points.
        tick(1'b1, 8192, "R10");
        tick(1'b1, -8192, "R10");
        // R3 and R5: dense back-to-back sweep across the range.
        for (int a = -8192; a <= 8192; a += 41) tick(1'b1, a, "R5");
        // R3 and R6: gapped stream with scattered angles.
        for (int i = 0; i < 300; i++) begin
            tick((i % 3) != 1, ((i * 1237) % 16385) - 8192, "R3");
        end
        for (int i = 0; i < LAT; i++) tick(1'b0, 0, "R6");
        // R2: reset with work in flight.
        for (int i = 0; i < 5; i++) tick(1'b1, 1000 * i - 2000, "R3");
        do_reset(1);
        for (int i = 0; i < 20; i++) tick(i < 6, 3001 - 1400 * i, "R3");
        for (int i = 0; i < LAT; i++) tick(1'b0, 0, "R6");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 50000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule